// File: doc/BRIEF.md
# Display FIFO Burst Refill Controller

This controller keeps a display FIFO supplied with data. It watches how many quad-words (QWs) the FIFO holds. When that level, plus any QWs already requested but not yet delivered, drops below a programmable low-water threshold, it raises one memory request. The size of that request comes from a 3-bit burst code. Only one burst is in flight at a time. The controller counts the returning QWs and raises no new request until the whole burst has arrived.

The burst code maps to (code+1)×8 QWs. Two memory modes restrict the legal codes:
- With trickle feed on, the smallest burst is not allowed.
- With tiled memory, only sizes that are a multiple of 16 QWs are allowed.

When a code is illegal for the current mode, the controller uses the next larger legal size and raises a configuration error. A threshold of 32 or more also raises the error, and the controller then uses 31 as the threshold. FIFO storage and address generation live outside this block.

Top module: `dfifo_refill_ctrl`

## Requirements
- R1: For a legal code c (0..7), `req_size` equals (c+1)×8 QWs, giving 8, 16, 24 … 64.
- R2: With `cfg_trickle`=1 and code 0, the burst size is 16 QWs and `cfg_err` is 1.
- R3: With `cfg_tiled`=1 and an even code (0, 2, 4, 6), the code is moved up by one, giving 16, 32, 48 or 64 QWs, and `cfg_err` is 1. This is applied after the R2 adjustment.
- R4: A `cfg_watermark` of 32 or more sets `cfg_err`, and the threshold used is 31.
- R5: With nothing outstanding and no request pending, `req_valid` rises at the clock edge where `fifo_level` + outstanding QWs is below the threshold. At or above the threshold, no request is raised.
- R6: While `req_valid` is 1 and `req_ack` is 0, `req_valid` and `req_size` hold. An edge with `req_ack`=1 drops `req_valid` and loads the outstanding count with `req_size`.
- R7: After an acknowledge, no new request is raised until one `ret_strobe` has been seen for each QW of the burst.
- R8: `ret_strobe` with nothing outstanding has no effect, and `req_ack` with no pending request has no effect.
- R9: While reset is active, `req_valid` and `cfg_err` are 0 and the outstanding count is 0.
- R10: `cfg_err` is registered. It follows the current configuration one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_burst_code | input | 3 | Burst size code, size (code+1)×8 QWs |
| cfg_watermark | input | 6 | Low-water threshold in QWs |
| cfg_trickle | input | 1 | Trickle-feed mode |
| cfg_tiled | input | 1 | Tiled-memory mode |
| fifo_level | input | 7 | QWs currently held in the FIFO |
| req_valid | output | 1 | Memory request pending |
| req_ack | input | 1 | Request accepted |
| req_size | output | 7 | Burst size in QWs, valid with `req_valid` |
| ret_strobe | input | 1 | One QW of the burst returned |
| cfg_err | output | 1 | Illegal burst code or threshold for the current mode |

## Verification
A wrong outstanding count shows up at the ports as a request raised too early, after fewer than `req_size` strobes, or as a request that never comes back. The latter is the case when a stray strobe has wrapped the count. Either one is visible within one cycle of the burst's last strobe. A fault in the decode or error logic shows in the first `req_size` or `cfg_err` sample one edge after the configuration is applied. The bench therefore compares all three outputs every cycle against a reference model. It also runs directed sequences that count strobes exactly.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int CODE_W   = 3;
  localparam int WM_W     = 6;
  localparam int QW_STEP  = 8;
  localparam int SIZE_W   = $clog2(QW_STEP * (1 << CODE_W)) + 1;
  localparam int WM_LIMIT = 32;

  typedef logic [CODE_W-1:0] burst_code_t;
  typedef logic [SIZE_W-1:0] qw_size_t;

  typedef struct packed {
    qw_size_t size;
    logic     illegal;
  } burst_dec_t;
endpackage

// File: rtl/dfr_rst_sync.sv
module dfr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dfr_burst_decode.sv
module dfr_burst_decode
  import dfr_pkg::*;
(
  input  burst_code_t code,
  input  logic        trickle,
  input  logic        tiled,
  output burst_dec_t  dec
);
  burst_code_t code_tr;
  burst_code_t code_fin;

  always_comb begin
    code_tr = code;
    if (trickle && (code == '0)) code_tr = burst_code_t'(1);
    code_fin = code_tr;
    if (tiled && !code_tr[0]) code_fin = code_tr + burst_code_t'(1);
    dec.illegal = (code_fin != code);
    dec.size    = qw_size_t'((32'(code_fin) + 32'd1) * QW_STEP);
  end
endmodule

// File: rtl/dfr_outstanding.sv
module dfr_outstanding
  import dfr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  qw_size_t load_val,
  input  logic     ret,
  output qw_size_t count,
  output logic     empty
);
  qw_size_t cnt_q, cnt_d;
  logic     cnt_en;

  assign empty  = (cnt_q == '0);
  assign cnt_en = load | (ret & ~empty);
  assign count  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (ret && !empty)  cnt_d = cnt_q - qw_size_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !empty && !load) |=> (cnt_q == $past(cnt_q) - qw_size_t'(1))); // R7
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !load) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/dfr_wm_check.sv
module dfr_wm_check
  import dfr_pkg::*;
#(
  parameter int OCC_W = 7
) (
  input  logic [OCC_W-1:0] level,
  input  qw_size_t         outstanding,
  input  logic [WM_W-1:0]  watermark,
  output logic             below,
  output logic             wm_err
);
  localparam int SUM_W = ((OCC_W > SIZE_W) ? OCC_W : SIZE_W) + 1;
  localparam int CMP_W = (SUM_W > WM_W) ? SUM_W : WM_W;

  logic [SUM_W-1:0] occ_total;
  logic [CMP_W-1:0] wm_eff;

  always_comb begin
    occ_total = SUM_W'(level) + SUM_W'(outstanding);
    wm_err    = (32'(watermark) >= WM_LIMIT);
    wm_eff    = wm_err ? CMP_W'(WM_LIMIT - 1) : CMP_W'(watermark);
    below     = (CMP_W'(occ_total) < wm_eff);
  end
endmodule

// File: rtl/dfifo_refill_ctrl.sv
module dfifo_refill_ctrl
  import dfr_pkg::*;
#(
  parameter int OCC_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   cfg_burst_code,
  input  logic [WM_W-1:0]     cfg_watermark,
  input  logic                cfg_trickle,
  input  logic                cfg_tiled,
  input  logic [OCC_W-1:0]    fifo_level,
  output logic                req_valid,
  input  logic                req_ack,
  output logic [SIZE_W-1:0]   req_size,
  input  logic                ret_strobe,
  output logic                cfg_err
);
  logic       rst_n_s;
  burst_dec_t dec;
  qw_size_t   out_cnt;
  logic       out_empty;
  logic       below;
  logic       wm_err;
  logic       load;

  logic       req_q, req_d;
  qw_size_t   size_q, size_d;
  logic       err_q, err_d;
  logic       req_en;

  dfr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dfr_burst_decode u_dec (
    .code(cfg_burst_code), .trickle(cfg_trickle), .tiled(cfg_tiled), .dec(dec)
  );

  dfr_wm_check #(.OCC_W(OCC_W)) u_wm (
    .level(fifo_level), .outstanding(out_cnt), .watermark(cfg_watermark),
    .below(below), .wm_err(wm_err)
  );

  assign load = req_q & req_ack;

  dfr_outstanding u_out (
    .clk(clk), .rst_n(rst_n_s), .load(load), .load_val(size_q),
    .ret(ret_strobe), .count(out_cnt), .empty(out_empty)
  );

  always_comb begin
    req_d  = req_q;
    size_d = size_q;
    if (req_q) begin
      if (req_ack) req_d = 1'b0;
    end else if (out_empty && below) begin
      req_d  = 1'b1;
      size_d = dec.size;
    end
    req_en = (req_d != req_q);
    err_d  = dec.illegal | wm_err;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_q  <= 1'b0;
      size_q <= '0;
    end else if (req_en) begin
      req_q  <= req_d;
      size_q <= size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign req_valid = req_q;
  assign req_size  = size_q;
  assign cfg_err   = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_q && !req_ack) |=> (req_q && $stable(size_q))); // R6
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_q && req_ack) |=> !req_q); // R6
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_q |-> out_empty); // R7
  AST_TRICKLE_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_trickle && cfg_burst_code == '0) |=> cfg_err); // R2
  AST_WM_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (32'(cfg_watermark) >= WM_LIMIT) |=> cfg_err); // R4
endmodule

// File: tb/dfifo_refill_ctrl_tb.sv
module dfifo_refill_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] code;
  logic [5:0] wm;
  logic       tr, ti;
  logic [6:0] lvl;
  logic       ack, ret;
  logic       req_valid, cfg_err;
  logic [6:0] req_size;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  int m_v, m_size, m_out, m_err;

  always #2.5 clk = ~clk;

  dfifo_refill_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_code(code), .cfg_watermark(wm),
    .cfg_trickle(tr), .cfg_tiled(ti), .fifo_level(lvl), .req_valid(req_valid),
    .req_ack(ack), .req_size(req_size), .ret_strobe(ret), .cfg_err(cfg_err)
  );

  function automatic int exp_size(int c, int t, int l);
    int k = c;
    if (t != 0 && k == 0) k = 1;
    if (l != 0 && (k % 2) == 0) k = k + 1;
    return (k + 1) * 8;
  endfunction

  function automatic int exp_illegal(int c, int t, int l);
    return (exp_size(c, t, l) != (c + 1) * 8) ? 1 : 0;
  endfunction

  function automatic string size_tag(int c, int t, int l);
    if (t != 0 && c == 0) return "R2";
    if (l != 0 && (c % 2) == 0) return "R3";
    return "R1";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int c, input int t, input int l, input int w,
                      input int lv, input int a, input int r);
    int n_v, n_size, n_out, n_err, weff;
    @(negedge clk);
    chk("R5", req_valid, m_v);
    if (m_v != 0) chk("R1", req_size, m_size);
    chk("R10", cfg_err, m_err);
    code = 3'(c); tr = 1'(t); ti = 1'(l); wm = 6'(w); lvl = 7'(lv);
    ack = 1'(a); ret = 1'(r);
    weff  = (w >= 32) ? 31 : w;
    n_err = (exp_illegal(c, t, l) != 0 || w >= 32) ? 1 : 0;
    n_v = m_v; n_size = m_size; n_out = m_out;
    if (m_out != 0 && r != 0) n_out = m_out - 1;
    if (m_v != 0) begin
      if (a != 0) begin n_v = 0; n_out = m_size; end
    end else if (m_out == 0 && (lv + m_out) < weff) begin
      n_v = 1; n_size = exp_size(c, t, l);
    end
    @(posedge clk);
    #1;
    m_v = n_v; m_size = n_size; m_out = n_out; m_err = n_err;
  endtask

  task automatic drain();
    for (int i = 0; i < 70; i++) step(1, 0, 0, 31, 127, 0, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    code = 3'd1; tr = 0; ti = 0; wm = 6'd0; lvl = 7'd127; ack = 0; ret = 0;
    m_v = 0; m_size = 0; m_out = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", req_valid, 0);
    chk("R9", cfg_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1, 0, 0, 0, 127, 0, 0);

    // R8: stray strobes and acks while idle
    for (int i = 0; i < 10; i++) step(7, 0, 0, 31, 127, 1, 1);
    chk("R8", req_valid, 0);
    step(7, 0, 0, 31, 0, 0, 0);
    chk("R8", req_valid, 1);
    chk("R8", req_size, 64);
    step(7, 0, 0, 31, 0, 1, 0);
    // R7: exactly 64 strobes needed
    for (int i = 0; i < 63; i++) step(7, 0, 0, 31, 0, 0, 1);
    chk("R7", req_valid, 0);
    step(7, 0, 0, 31, 0, 0, 1);
    chk("R7", req_valid, 0);
    step(7, 0, 0, 31, 0, 0, 0);
    chk("R7", req_valid, 1);
    step(7, 0, 0, 31, 127, 1, 0);
    drain();

    // R6: hold while unacknowledged, even if the code changes
    step(2, 0, 0, 31, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      step(5, 0, 0, 31, 0, 0, 0);
      chk("R6", req_valid, 1);
      chk("R6", req_size, 24);
    end
    step(5, 0, 0, 31, 0, 1, 0);
    chk("R6", req_valid, 0);
    drain();

    // R5: level equal to threshold vs one below
    step(1, 0, 0, 20, 20, 0, 0);
    step(1, 0, 0, 20, 20, 0, 0);
    chk("R5", req_valid, 0);
    step(1, 0, 0, 20, 19, 0, 0);
    chk("R5", req_valid, 1);
    step(1, 0, 0, 20, 127, 1, 0);
    drain();

    // R4: oversized threshold clamps to 31 and flags
    step(1, 0, 0, 40, 31, 0, 0);
    step(1, 0, 0, 40, 31, 0, 0);
    chk("R4", req_valid, 0);
    chk("R4", cfg_err, 1);
    step(1, 0, 0, 40, 30, 0, 0);
    chk("R4", req_valid, 1);
    step(1, 0, 0, 40, 127, 1, 0);
    drain();

    // R10: error follows the configuration one edge later
    step(0, 1, 0, 0, 127, 0, 0);
    chk("R10", cfg_err, 1);
    step(1, 1, 0, 0, 127, 0, 0);
    chk("R10", cfg_err, 0);

    // R1 R2 R3: every code in every mode
    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 8; c++) begin
          step(c, t, l, 31, 0, 0, 0);
          chk(size_tag(c, t, l), req_size, exp_size(c, t, l));
          chk(size_tag(c, t, l), cfg_err, exp_illegal(c, t, l));
          step(c, t, l, 31, 127, 1, 0);
          drain();
        end

    // Constrained random phase
    begin
      int rc, rt, rl, rw;
      rc = 1; rt = 0; rl = 0; rw = 24;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 49) == 0) begin
          rc = $urandom_range(0, 7);
          rt = $urandom_range(0, 1);
          rl = $urandom_range(0, 1);
          rw = $urandom_range(0, 63);
        end
        step(rc, rt, rl, rw, $urandom_range(0, 90),
             ($urandom_range(0, 3) == 0) ? 1 : 0, $urandom_range(0, 1));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule